// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two 16-bit timer/counters. Software reaches them through a small byte-wide register port: each counter is exposed as a low and a high byte, a mode byte picks the counting mode, count source and gating for both timers, and a control byte carries the two run bits and the two overflow flags. A counter advances on a pulse of the shared `tick_en` input or, when it is set to count externally, on falling edges of its own count pin. A gate pin per timer can hold counting off while it is low.

Each timer runs in one of four modes. These are a 13-bit counter made of a 5-bit prescaler under an 8-bit counter, a plain 16-bit counter, an 8-bit counter that reloads from the high byte, and a split mode. In split mode timer 0 becomes two independent 8-bit counters and timer 1 freezes. Overflows raise the matching flag, which interrupt entry clears by pulsing the acknowledge input. Control and status pins are plain levels with no handshake. A register access completes in the cycle it is presented, so the register port has no back-pressure.

Top module: `tmr_pair`

## Requirements
- R1: Register offsets are 0 = timer 0 low, 1 = timer 0 high, 2 = timer 1 low, 3 = timer 1 high, 4 = mode byte, 5 = control byte. The mode byte holds timer 0 in bits 3:0 and timer 1 in bits 7:4: mode in bits 1:0, external source in bit 2, gate enable in bit 3. The control byte holds run 0 at bit 0, run 1 at bit 1, flag 0 at bit 4 and flag 1 at bit 5. After reset every register reads 0 and both flags are low.
- R2: In mode 1 the timer is a 16-bit up counter. Stepping from FFFFh to 0000h sets its flag.
- R3: In mode 2 the low byte counts. Stepping past FFh loads it from the high byte, sets the flag and leaves the high byte unchanged.
- R4: In mode 0 the low byte's bits 4:0 form a prescaler whose carry advances the high byte. Low-byte bits 7:5 hold their value. A carry out of the high byte sets the flag.
- R5: In mode 3, timer 0's low byte is an 8-bit counter governed by run 0, the source bit and the gate bit of timer 0, and its overflow sets flag 0. Timer 0's high byte is an 8-bit counter of internal ticks governed by run 1 alone, and its overflow sets flag 1.
- R6: With timer 1 in mode 3, timer 1 keeps its value whatever its run bit and the ticks do.
- R7: A timer counts only while its run bit is 1. If its gate bit is 1, it also needs its gate pin, synchronized over two clocks, to be high.
- R8: With the source bit at 1, a timer counts 1-to-0 transitions of its count pin after a two-stage synchronizer. Each edge is held pending until the next `tick_en` cycle, and one tick consumes at most one count however many edges came before it.
- R9: A flag is set by its overflow, cleared by a pulse on its acknowledge bit, and written directly by a control-byte write. An overflow in the same cycle wins over both.
- R10: A write to a count byte takes priority over counting in that cycle. Outside mode 3, a write to either byte of a timer cancels that timer's count for the cycle. In mode 3, each half is cancelled only by a write to itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Internal count tick, one count per high cycle |
| cnt_pin | input | 2 | External count pins, bit i for timer i |
| gate_pin | input | 2 | Gate pins, bit i for timer i |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| ovf_ack | input | 2 | Interrupt-entry acknowledge, clears flag i |
| ovf_flag | output | 2 | Overflow flags |

## Verification
The bench builds the block with its default parameters: 8-bit count bytes, a 5-bit prescaler and two synchronizer stages. With these values every overflow boundary can be reached by preloading a count byte near all-ones and applying a handful of ticks. This covers the 16-bit wrap, the 13-bit prescaler carry with its upper low-byte bits held, the reload step and both split-half overflows. The two-stage synchronizer keeps the gate and external-edge latencies short enough to place pin pulses and tick windows at exact cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    TM_13     = 2'd0,
    TM_16     = 2'd1,
    TM_RELOAD = 2'd2,
    TM_SPLIT  = 2'd3
  } tmr_mode_e;

  localparam int unsigned NUM_TMR  = 2;
  localparam int unsigned ADDR_W   = 3;
  localparam logic [2:0]  A_T0_LO  = 3'd0;
  localparam logic [2:0]  A_T0_HI  = 3'd1;
  localparam logic [2:0]  A_T1_LO  = 3'd2;
  localparam logic [2:0]  A_T1_HI  = 3'd3;
  localparam logic [2:0]  A_MODE   = 3'd4;
  localparam logic [2:0]  A_CTRL   = 3'd5;
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic tick,
  output logic level,
  output logic cnt_evt
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              pend_q;
  logic              fall;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[s] <= 1'b0;
        else if (s == 0) sync_q[s] <= pin;
        else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign level = sync_q[STAGES-1];
  assign fall  = prev_q & ~level;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= level;
      pend_q <= fall | (pend_q & ~tick);
    end
  end

  assign cnt_evt = tick & pend_q;

  // R8: an edge is remembered until a tick consumes it
  p_edge_pends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> pend_q);
  // R8: a tick leaves nothing pending unless a fresh edge arrived
  p_one_per_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !fall) |=> !pend_q);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int unsigned W        = 8,
  parameter int unsigned PRE_W    = 5,
  parameter bit          SPLIT_OK = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  tmr_mode_e    mode,
  input  logic         inc_main,
  input  logic         inc_hi,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lo_q,
  output logic [W-1:0] hi_q,
  output logic         ovf_main,
  output logic         ovf_hi
);
  localparam int unsigned FULL_W = 2 * W;

  logic [W-1:0]   lo_n, hi_n;
  logic [W:0]     lo_inc, hi_inc;
  logic [PRE_W:0] pre_inc;
  logic [FULL_W:0] full_inc;
  logic           split;

  assign lo_inc   = {1'b0, lo_q} + 1'b1;
  assign hi_inc   = {1'b0, hi_q} + 1'b1;
  assign pre_inc  = {1'b0, lo_q[PRE_W-1:0]} + 1'b1;
  assign full_inc = {1'b0, hi_q, lo_q} + 1'b1;
  assign split    = SPLIT_OK && (mode == TM_SPLIT);

  always_comb begin
    lo_n     = lo_q;
    hi_n     = hi_q;
    ovf_main = 1'b0;
    ovf_hi   = 1'b0;
    if (split) begin
      if (inc_main && !wr_lo) begin
        lo_n     = lo_inc[W-1:0];
        ovf_main = lo_inc[W];
      end
      if (inc_hi && !wr_hi) begin
        hi_n   = hi_inc[W-1:0];
        ovf_hi = hi_inc[W];
      end
    end else if (inc_main && !wr_lo && !wr_hi) begin
      unique case (mode)
        TM_13: begin
          lo_n[PRE_W-1:0] = pre_inc[PRE_W-1:0];
          if (pre_inc[PRE_W]) begin
            hi_n     = hi_inc[W-1:0];
            ovf_main = hi_inc[W];
          end
        end
        TM_16: begin
          {hi_n, lo_n} = full_inc[FULL_W-1:0];
          ovf_main     = full_inc[FULL_W];
        end
        TM_RELOAD: begin
          if (lo_inc[W]) begin
            lo_n     = hi_q;
            ovf_main = 1'b1;
          end else begin
            lo_n = lo_inc[W-1:0];
          end
        end
        default: ;
      endcase
    end
    if (wr_lo) lo_n = wdata;
    if (wr_hi) hi_n = wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> lo_q == $past(wdata));
  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TM_RELOAD && inc_main && !wr_lo && !wr_hi && lo_q == {W{1'b1}})
      |=> lo_q == $past(hi_q));
  p_prescale_top_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TM_13 && !wr_lo) |=> lo_q[W-1:PRE_W] == $past(lo_q[W-1:PRE_W]));
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned PRE_W       = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [1:0]        cnt_pin,
  input  logic [1:0]        gate_pin,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic [1:0]        ovf_ack,
  output logic [1:0]        ovf_flag
);
  localparam int unsigned FIELD_W = 4;

  logic [W-1:0]       mode_q;
  logic [1:0]         run_q;
  logic [1:0]         flag_q;
  logic [W-1:0]       cnt_lo [NUM_TMR];
  logic [W-1:0]       cnt_hi [NUM_TMR];
  logic [NUM_TMR-1:0] ovf_main, ovf_hi;
  logic [NUM_TMR-1:0] gate_lvl, ext_evt, enable, src_pulse;
  logic [NUM_TMR-1:0] inc_main, inc_hi;
  logic [NUM_TMR-1:0] wr_lo, wr_hi;
  tmr_mode_e          tmode [NUM_TMR];
  logic [1:0]         flag_set;
  logic               wr_ctrl;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);

  generate
    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
      logic use_ext, use_gate;
      assign tmode[i]  = tmr_mode_e'(mode_q[FIELD_W*i +: 2]);
      assign use_ext   = mode_q[FIELD_W*i + 2];
      assign use_gate  = mode_q[FIELD_W*i + 3];
      assign wr_lo[i]  = reg_wr && (reg_addr == 3'(2*i));
      assign wr_hi[i]  = reg_wr && (reg_addr == 3'(2*i + 1));

      tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
        .clk(clk), .rst_n(rst_n), .pin(cnt_pin[i]), .tick(tick_en),
        .level(), .cnt_evt(ext_evt[i]));
      tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
        .clk(clk), .rst_n(rst_n), .pin(gate_pin[i]), .tick(1'b0),
        .level(gate_lvl[i]), .cnt_evt());

      assign enable[i]    = run_q[i] && (!use_gate || gate_lvl[i]);
      assign src_pulse[i] = use_ext ? ext_evt[i] : tick_en;

      if (i == 0) begin : g_split_capable
        assign inc_main[i] = enable[i] && src_pulse[i];
        assign inc_hi[i]   = (tmode[i] == TM_SPLIT) && run_q[1] && tick_en;
      end else begin : g_plain
        assign inc_main[i] = (tmode[i] != TM_SPLIT) && enable[i] && src_pulse[i];
        assign inc_hi[i]   = 1'b0;
      end

      tmr_counter #(.W(W), .PRE_W(PRE_W), .SPLIT_OK(i == 0)) u_cnt (
        .clk(clk), .rst_n(rst_n), .mode(tmode[i]),
        .inc_main(inc_main[i]), .inc_hi(inc_hi[i]),
        .wr_lo(wr_lo[i]), .wr_hi(wr_hi[i]), .wdata(reg_wdata),
        .lo_q(cnt_lo[i]), .hi_q(cnt_hi[i]),
        .ovf_main(ovf_main[i]), .ovf_hi(ovf_hi[i]));
    end
  endgenerate

  assign flag_set[0] = ovf_main[0];
  assign flag_set[1] = ovf_hi[0] | ovf_hi[1] | ovf_main[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      if (reg_wr && reg_addr == A_MODE) mode_q <= reg_wdata;
      if (wr_ctrl) run_q <= reg_wdata[1:0];
      for (int i = 0; i < 2; i++) begin
        if (flag_set[i])     flag_q[i] <= 1'b1;
        else if (ovf_ack[i]) flag_q[i] <= 1'b0;
        else if (wr_ctrl)    flag_q[i] <= reg_wdata[4+i];
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_T0_LO: reg_rdata = cnt_lo[0];
      A_T0_HI: reg_rdata = cnt_hi[0];
      A_T1_LO: reg_rdata = cnt_lo[1];
      A_T1_HI: reg_rdata = cnt_hi[1];
      A_MODE:  reg_rdata = mode_q;
      A_CTRL:  reg_rdata = {2'b00, flag_q, 2'b00, run_q};
      default: reg_rdata = '0;
    endcase
  end

  assign ovf_flag = flag_q;

  p_t1_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tmode[1] == TM_SPLIT && !wr_lo[1] && !wr_hi[1])
      |=> ($stable(cnt_lo[1]) && $stable(cnt_hi[1])));
  p_gate_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[7] && !gate_lvl[1] && !wr_lo[1] && !wr_hi[1])
      |=> ($stable(cnt_lo[1]) && $stable(cnt_hi[1])));
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_ack[0] && !flag_set[0]) |=> !ovf_flag[0]);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set[1] |=> ovf_flag[1]);
endmodule

// File: tb/tmr_pair_bench.sv
module tmr_pair_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [1:0] cnt_pin = 2'b11;
  logic [1:0] gate_pin = 2'b00;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [1:0] ovf_ack = 2'b00;
  logic [1:0] ovf_flag;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  tmr_pair u_tmr_pair (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_pin(cnt_pin),
    .gate_pin(gate_pin), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovf_ack(ovf_ack),
    .ovf_flag(ovf_flag));

  // mode, preset hi, preset lo, ticks, expected hi, expected lo, expected flag 0
  localparam logic [50:0] VECS [6] = '{
    {2'd1, 8'hFF, 8'hF0, 16'd20,  8'h00, 8'h04, 1'b1},  // R2 wrap
    {2'd1, 8'h12, 8'hFF, 16'd1,   8'h13, 8'h00, 1'b0},  // R2 carry
    {2'd0, 8'hFF, 8'hFE, 16'd3,   8'h00, 8'hE1, 1'b1},  // R4 overflow, top bits held
    {2'd2, 8'h80, 8'hFD, 16'd5,   8'h80, 8'h82, 1'b1},  // R3 reload
    {2'd1, 8'h00, 8'h00, 16'd300, 8'h01, 8'h2C, 1'b0},  // R2 long run
    {2'd0, 8'h03, 8'h1F, 16'd1,   8'h04, 8'h00, 1'b0}   // R4 prescale carry
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic pulses(input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); cnt_pin[idx] = 1'b0;
      repeat (4) @(negedge clk);
      cnt_pin[idx] = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of every register
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 reset reg", {8'h0, v}, 16'h0);
    end
    chk("R1 reset flags", {14'h0, ovf_flag}, 16'h0);

    // table walk on timer 0
    for (int i = 0; i < 6; i++) begin
      wr(3'd5, 8'h00);
      wr(3'd4, {6'b0, VECS[i][50:49]});
      wr(3'd0, VECS[i][40:33]);
      wr(3'd1, VECS[i][48:41]);
      wr(3'd5, 8'h01);
      ticks(int'(VECS[i][32:17]));
      rd(3'd1, v); chk("R2/R3/R4 hi", {8'h0, v}, {8'h0, VECS[i][16:9]});
      rd(3'd0, v); chk("R2/R3/R4 lo", {8'h0, v}, {8'h0, VECS[i][8:1]});
      chk("R2/R3/R4 flag", {15'h0, ovf_flag[0]}, {15'h0, VECS[i][0]});
    end

    // R10: write to the low byte beats the tick in the same cycle
    wr(3'd5, 8'h00); wr(3'd4, 8'h01); wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    wr(3'd5, 8'h01);
    @(negedge clk);
    tick_en = 1'b1; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h55;
    @(negedge clk);
    tick_en = 1'b0; reg_wr = 1'b0;
    rd(3'd0, v); chk("R10 lo write wins", {8'h0, v}, 16'h0055);
    rd(3'd1, v); chk("R10 hi untouched", {8'h0, v}, 16'h0000);

    // R7: gate low blocks counting, gate high lets it through
    wr(3'd5, 8'h00); wr(3'd4, 8'h09); wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    wr(3'd5, 8'h01);
    gate_pin[0] = 1'b0;
    repeat (4) @(negedge clk);
    ticks(10);
    rd(3'd0, v); chk("R7 gated off", {8'h0, v}, 16'h0000);
    gate_pin[0] = 1'b1;
    repeat (4) @(negedge clk);
    ticks(10);
    rd(3'd0, v); chk("R7 gated on", {8'h0, v}, 16'h000A);

    // R8: external falling edges
    wr(3'd5, 8'h00); wr(3'd4, 8'h05); wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    wr(3'd5, 8'h01);
    @(negedge clk); tick_en = 1'b1;
    repeat (6) @(negedge clk);
    pulses(0, 3);
    repeat (6) @(negedge clk);
    tick_en = 1'b0;
    rd(3'd0, v); chk("R8 three edges", {8'h0, v}, 16'h0003);
    pulses(0, 3);
    repeat (4) @(negedge clk);
    ticks(1);
    rd(3'd0, v); chk("R8 one count per tick", {8'h0, v}, 16'h0004);
    ticks(5);
    rd(3'd0, v); chk("R8 no edge no count", {8'h0, v}, 16'h0004);

    // R5: split mode on timer 0, timer 1 in 16-bit mode
    wr(3'd5, 8'h00); wr(3'd4, 8'h13);
    wr(3'd0, 8'hFE); wr(3'd1, 8'h10); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd5, 8'h01);
    ticks(3);
    rd(3'd0, v); chk("R5 low half", {8'h0, v}, 16'h0001);
    rd(3'd1, v); chk("R5 high half idle", {8'h0, v}, 16'h0010);
    chk("R5 low overflow flag", {14'h0, ovf_flag}, 16'h0001);
    wr(3'd5, 8'h12);
    ticks(2);
    rd(3'd1, v); chk("R5 high half on run1", {8'h0, v}, 16'h0012);
    rd(3'd0, v); chk("R5 low half stopped", {8'h0, v}, 16'h0001);
    wr(3'd1, 8'hFF);
    ticks(1);
    rd(3'd1, v); chk("R5 high half wrap", {8'h0, v}, 16'h0000);
    chk("R5 high overflow sets flag1", {14'h0, ovf_flag}, 16'h0003);

    // R6: timer 1 frozen in mode 3
    wr(3'd5, 8'h00); wr(3'd4, 8'h30); wr(3'd2, 8'h44); wr(3'd3, 8'h55);
    wr(3'd5, 8'h02);
    ticks(8);
    rd(3'd2, v); chk("R6 t1 lo held", {8'h0, v}, 16'h0044);
    rd(3'd3, v); chk("R6 t1 hi held", {8'h0, v}, 16'h0055);

    // R9: flag set by overflow, cleared by ack and by software
    wr(3'd5, 8'h00); wr(3'd4, 8'h10); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    wr(3'd5, 8'h02);
    ticks(1);
    chk("R9 t1 overflow flag", {14'h0, ovf_flag}, 16'h0002);
    @(negedge clk); ovf_ack = 2'b10;
    @(negedge clk); ovf_ack = 2'b00;
    chk("R9 ack clears", {14'h0, ovf_flag}, 16'h0000);
    wr(3'd5, 8'h30);
    chk("R9 software set", {14'h0, ovf_flag}, 16'h0003);
    wr(3'd5, 8'h00);
    chk("R9 software clear", {14'h0, ovf_flag}, 16'h0000);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule